// File: doc/BRIEF.md
# Debug Communications Channel Mailbox

This block is a one-word mailbox in each direction between a debug host and a processor core. The host sees two registers through a register-file port with address, write and read strobes. The data register carries words both ways: a host write sends a word to the core, and a host read takes the word the core left. The control register reports two full flags and a fixed version number in its top nibble. The core sees the same control word on a plain output.

On the core side, the host-to-core word is offered as a valid/ready stream. `core_rx_valid` equals the host-data-waiting flag, and a transfer (valid and ready high at a clock edge) consumes the word. The core-to-host word is accepted from a valid/ready stream. `core_tx_ready` is high when the core-to-host slot is empty, or when the host consumes the slot in the same cycle.

Back-pressure on the core side is advisory. A push offered while `core_tx_ready` is low is dropped and flagged, not stalled. A host write into a full host-to-core slot overwrites the word and is flagged. All logic runs on one clock.

Top module: `dcc_mailbox`

## Requirements
- R1: After reset both flags are 0, both data words are 0, the overrun pulses are 0 and the control word reads 0x6000_0000 with the default version.
- R2: Control word layout: bit 0 is the host-data-waiting flag (R), bit 1 is the core-data-waiting flag (W), bits 31:28 hold the VERSION parameter (default 6), and all other bits read 0. The core sees the same word on `core_ctrl`.
- R3: A host write to address 5 loads the host-to-core word and sets R at that edge. `core_rx_valid` follows R, and `core_rx_data` shows the word.
- R4: A core transfer (`core_rx_valid` and `core_rx_ready` high) clears R at that edge. `core_rx_ready` with R at 0 changes nothing.
- R5: A host write to address 5 while R is 1, with no core transfer in the same cycle, overwrites the word and keeps R at 1. `h2c_overrun` is then high for exactly the next cycle.
- R6: A core push (`core_tx_valid` with `core_tx_ready`) loads the core-to-host word and sets W. `core_tx_ready` is high whenever W is 0.
- R7: A core push while W is 1, with no host read of address 5 in that cycle, is dropped: the word is kept and W stays 1. `c2h_overrun` is then high for exactly the next cycle.
- R8: `dbg_rdata` at address 5 shows the core-to-host word, and a host read there clears W at that edge. A second read without a new push returns the same word, with W still 0.
- R9: A host read at address 4 returns the control word and changes no flag. Host writes to address 4 or to any unused address have no effect. Reads of unused addresses return 0.
- R10: Same-cycle collisions resolve in favour of the new word, with no overrun. A host write to address 5 together with a core transfer leaves R at 1 holding the new word. A core push together with a host read of address 5 while W is 1 is accepted (`core_tx_ready` high), and W stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_addr | input | 5 | Host register address (4 control, 5 data) |
| dbg_wr | input | 1 | Host write strobe |
| dbg_rd | input | 1 | Host read strobe (consumes data at address 5) |
| dbg_wdata | input | 32 | Host write data |
| dbg_rdata | output | 32 | Host read data, combinational from dbg_addr |
| core_rx_valid | output | 1 | Host-to-core word available (R) |
| core_rx_ready | input | 1 | Core takes the host-to-core word |
| core_rx_data | output | 32 | Host-to-core word |
| core_tx_valid | input | 1 | Core offers a core-to-host word |
| core_tx_ready | output | 1 | Core-to-host slot can accept |
| core_tx_data | input | 32 | Core-to-host word |
| core_ctrl | output | 32 | Control word as seen by the core |
| h2c_overrun | output | 1 | One-cycle pulse after a host overwrite |
| c2h_overrun | output | 1 | One-cycle pulse after a dropped core push |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a host data write and a core pop of the host-to-core slot. The bench raises `dbg_wr` at address 5 and `core_rx_ready` on one edge while R is set. It then judges that the core received the old word, that R remains set with the new word, and that no overrun pulse follows.

The second pair is a host data read and a core push while W is set. The bench checks that `core_tx_ready` is high in that cycle and that the read returns the old word. It then checks that W stays set with the new word, which a following read returns.

// File: rtl/dcc_mbox_pkg.sv
package dcc_mbox_pkg;
  // which host register an access targets
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_DATA = 2'd2
  } dbg_sel_e;

  // handshake flags of the two slots
  typedef struct packed {
    logic c2h_full;  // W
    logic h2c_full;  // R
  } mbox_flags_t;
endpackage

// File: rtl/dcc_dbg_decode.sv
module dcc_dbg_decode
  import dcc_mbox_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int CTRL_ADDR = 4,
  parameter int DATA_ADDR = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output dbg_sel_e          sel,
  output logic              data_wr,
  output logic              data_rd
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);

  always_comb begin
    if (addr == A_DATA)      sel = SEL_DATA;
    else if (addr == A_CTRL) sel = SEL_CTRL;
    else                     sel = SEL_NONE;
  end

  // only the data register has side effects
  assign data_wr = wr && (sel == SEL_DATA);
  assign data_rd = rd && (sel == SEL_DATA);
endmodule

// File: rtl/dcc_mbox_slot.sv
module dcc_mbox_slot #(
  parameter int DATA_W    = 32,
  parameter bit OVERWRITE = 1'b0  // 1: load into full slot replaces, 0: dropped
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              take,
  output logic              can_load,
  output logic              full,
  output logic [DATA_W-1:0] word,
  output logic              overrun
);
  logic accepted;
  logic collide;

  assign can_load = !full || take || OVERWRITE;
  assign accepted = load && can_load;
  // a load meeting a full slot that is not drained this cycle
  assign collide  = load && full && !take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= 1'b0;
      word    <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= collide;
      if (accepted) begin
        full <= 1'b1;
        word <= load_data;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dcc_ctrl_word.sv
module dcc_ctrl_word
  import dcc_mbox_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FLAG_W  = 6,
  parameter int VER_W   = 4,
  parameter int VERSION = 6
) (
  input  mbox_flags_t       flags,
  output logic [DATA_W-1:0] ctrl
);
  localparam int SPARE_W = FLAG_W - 2;
  localparam int PAD_W   = DATA_W - VER_W - FLAG_W;
  localparam logic [VER_W-1:0] VER_V = VER_W'(VERSION);

  logic [FLAG_W-1:0] flag_field;

  assign flag_field = {{SPARE_W{1'b0}}, flags.c2h_full, flags.h2c_full};

  generate
    if (PAD_W > 0) begin : g_pad
      assign ctrl = {VER_V, {PAD_W{1'b0}}, flag_field};
    end else begin : g_nopad
      assign ctrl = {VER_V, flag_field};
    end
  endgenerate
endmodule

// File: rtl/dcc_mailbox.sv
module dcc_mailbox
  import dcc_mbox_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int CTRL_ADDR = 4,
  parameter int DATA_ADDR = 5,
  parameter int FLAG_W    = 6,
  parameter int VER_W     = 4,
  parameter int VERSION   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic              dbg_wr,
  input  logic              dbg_rd,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic              core_rx_valid,
  input  logic              core_rx_ready,
  output logic [DATA_W-1:0] core_rx_data,
  input  logic              core_tx_valid,
  output logic              core_tx_ready,
  input  logic [DATA_W-1:0] core_tx_data,
  output logic [DATA_W-1:0] core_ctrl,
  output logic              h2c_overrun,
  output logic              c2h_overrun
);
  dbg_sel_e          sel;
  logic              data_wr;
  logic              data_rd;
  logic              rx_fire;
  logic              h2c_can_load;
  logic              h2c_full;
  logic              c2h_full;
  logic [DATA_W-1:0] h2c_word;
  logic [DATA_W-1:0] c2h_word;
  mbox_flags_t       flags;

  dcc_dbg_decode #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_dec (
    .addr(dbg_addr), .wr(dbg_wr), .rd(dbg_rd),
    .sel(sel), .data_wr(data_wr), .data_rd(data_rd)
  );

  assign rx_fire = core_rx_valid && core_rx_ready;

  // host to core: a host write into a full slot replaces the word
  dcc_mbox_slot #(.DATA_W(DATA_W), .OVERWRITE(1'b1)) u_h2c (
    .clk(clk), .rst_n(rst_n),
    .load(data_wr), .load_data(dbg_wdata), .take(rx_fire),
    .can_load(h2c_can_load), .full(h2c_full), .word(h2c_word),
    .overrun(h2c_overrun)
  );

  // core to host: a core push into a full slot is dropped
  dcc_mbox_slot #(.DATA_W(DATA_W), .OVERWRITE(1'b0)) u_c2h (
    .clk(clk), .rst_n(rst_n),
    .load(core_tx_valid), .load_data(core_tx_data), .take(data_rd),
    .can_load(core_tx_ready), .full(c2h_full), .word(c2h_word),
    .overrun(c2h_overrun)
  );

  assign flags.h2c_full = h2c_full;
  assign flags.c2h_full = c2h_full;

  dcc_ctrl_word #(
    .DATA_W(DATA_W), .FLAG_W(FLAG_W), .VER_W(VER_W), .VERSION(VERSION)
  ) u_ctrl (
    .flags(flags), .ctrl(core_ctrl)
  );

  assign core_rx_valid = h2c_full;
  assign core_rx_data  = h2c_word;

  always_comb begin
    unique case (sel)
      SEL_DATA: dbg_rdata = c2h_word;
      SEL_CTRL: dbg_rdata = core_ctrl;
      default:  dbg_rdata = '0;
    endcase
  end

  // the host-to-core slot always accepts; its ready is not a port
  logic unused_ok;
  assign unused_ok = h2c_can_load;
endmodule

// File: rtl/dcc_mailbox_chk.sv
module dcc_mailbox_chk #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int CTRL_ADDR = 4,
  parameter int DATA_ADDR = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] dbg_addr,
  input logic              dbg_wr,
  input logic              dbg_rd,
  input logic              core_rx_valid,
  input logic              core_rx_ready,
  input logic              core_tx_valid,
  input logic              core_tx_ready,
  input logic [DATA_W-1:0] core_ctrl,
  input logic              h2c_overrun,
  input logic              c2h_overrun,
  input logic [DATA_W-1:0] c2h_word
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);

  logic wr5, rd5, rd4, rx_fire, tx_fire;
  assign wr5     = dbg_wr && dbg_addr == A_DATA;
  assign rd5     = dbg_rd && dbg_addr == A_DATA;
  assign rd4     = dbg_rd && dbg_addr == A_CTRL;
  assign rx_fire = core_rx_valid && core_rx_ready;
  assign tx_fire = core_tx_valid && core_tx_ready;

  p_load_sets_r_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr5 |=> core_ctrl[0]);

  p_pop_clears_r_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && !wr5) |=> !core_ctrl[0]);

  p_overwrite_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ctrl[0] && wr5 && !rx_fire) |=> (h2c_overrun && core_ctrl[0]));

  p_push_sets_w_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |=> core_ctrl[1]);

  p_ready_when_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !core_ctrl[1] |-> core_tx_ready);

  p_drop_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_tx_valid && !core_tx_ready) |=> (c2h_overrun && $stable(c2h_word)));

  p_consume_clears_w_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd5 && !tx_fire) |=> !core_ctrl[1]);

  p_ctrl_read_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd4 && !dbg_wr && !rx_fire && !core_tx_valid) |=> $stable(core_ctrl));

  p_collide_h2c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ctrl[0] && wr5 && rx_fire) |=> (core_ctrl[0] && !h2c_overrun));

  p_collide_c2h_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ctrl[1] && rd5 && core_tx_valid) |=> (core_ctrl[1] && !c2h_overrun));
endmodule

bind dcc_mailbox dcc_mailbox_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (.*);

// File: tb/dcc_mailbox_tb_top.sv
module dcc_mailbox_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  dbg_addr = '0;
  logic        dbg_wr = 1'b0, dbg_rd = 1'b0;
  logic [31:0] dbg_wdata = '0, dbg_rdata;
  logic        core_rx_valid, core_rx_ready = 1'b0;
  logic [31:0] core_rx_data;
  logic        core_tx_valid = 1'b0, core_tx_ready;
  logic [31:0] core_tx_data = '0;
  logic [31:0] core_ctrl;
  logic        h2c_overrun, c2h_overrun;
  logic [31:0] v_rdata, v_rx_data, v_ctrl;
  logic        v_rx_valid, v_tx_ready, v_h2c_ov, v_c2h_ov;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] core_q[$];  // words the core must receive, in order

  always #(CLK_P/2) clk = ~clk;

  dcc_mailbox dut_i (
    .clk, .rst_n, .dbg_addr, .dbg_wr, .dbg_rd, .dbg_wdata, .dbg_rdata,
    .core_rx_valid, .core_rx_ready, .core_rx_data,
    .core_tx_valid, .core_tx_ready, .core_tx_data,
    .core_ctrl, .h2c_overrun, .c2h_overrun
  );

  dcc_mailbox #(.VERSION(9)) dut_v (
    .clk, .rst_n, .dbg_addr(5'd0), .dbg_wr(1'b0), .dbg_rd(1'b0),
    .dbg_wdata(32'd0), .dbg_rdata(v_rdata),
    .core_rx_valid(v_rx_valid), .core_rx_ready(1'b0), .core_rx_data(v_rx_data),
    .core_tx_valid(1'b0), .core_tx_ready(v_tx_ready), .core_tx_data(32'd0),
    .core_ctrl(v_ctrl), .h2c_overrun(v_h2c_ov), .c2h_overrun(v_c2h_ov)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // monitor: every core transfer must deliver the next expected word (R3, R4)
  always @(posedge clk) begin
    if (rst_n && core_rx_valid && core_rx_ready) begin
      if (core_q.size() == 0) chk("R4 unexpected core transfer", 32'd1, 32'd0);
      else chk("R3 core receives word", core_rx_data, core_q.pop_front());
    end
  end

  task automatic dbg_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk); dbg_addr = a; dbg_wr = 1'b1; dbg_wdata = d;
    if (a == 5'd5) begin
      if (core_rx_valid) void'(core_q.pop_back());  // overwrite replaces
      core_q.push_back(d);
    end
    @(negedge clk); dbg_wr = 1'b0; dbg_addr = '0;
  endtask

  task automatic dbg_read(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); dbg_addr = a; dbg_rd = 1'b1;
    #1 d = dbg_rdata;
    @(negedge clk); dbg_rd = 1'b0; dbg_addr = '0;
  endtask

  task automatic core_pop();
    @(negedge clk); core_rx_ready = 1'b1;
    @(negedge clk); core_rx_ready = 1'b0;
  endtask

  task automatic core_push(logic [31:0] d);
    @(negedge clk); core_tx_valid = 1'b1; core_tx_data = d;
    @(negedge clk); core_tx_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    chk("R1 ctrl after reset", core_ctrl, 32'h6000_0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rx_valid after reset", {31'd0, core_rx_valid}, 32'd0);
    chk("R1 rx_data after reset", core_rx_data, 32'd0);
    chk("R1 tx_ready after reset", {31'd0, core_tx_ready}, 32'd1);
    chk("R1 overrun after reset", {30'd0, h2c_overrun, c2h_overrun}, 32'd0);
    chk("R2 version parameter", v_ctrl, 32'h9000_0000);
    dbg_read(5'd5, rd);
    chk("R1 data word after reset", rd, 32'd0);

    // R3: host write
    dbg_write(5'd5, 32'hA1A1_0001);
    chk("R3 R set", core_ctrl, 32'h6000_0001);
    chk("R3 rx_valid", {31'd0, core_rx_valid}, 32'd1);
    chk("R3 rx_data", core_rx_data, 32'hA1A1_0001);
    chk("R3 no overrun", {31'd0, h2c_overrun}, 32'd0);

    // R5: overwrite while R set
    dbg_write(5'd5, 32'hA2A2_0002);
    chk("R5 overrun pulse", {31'd0, h2c_overrun}, 32'd1);
    chk("R5 word replaced", core_rx_data, 32'hA2A2_0002);
    chk("R5 R stays", {31'd0, core_ctrl[0]}, 32'd1);
    @(negedge clk);
    chk("R5 pulse one cycle", {31'd0, h2c_overrun}, 32'd0);

    // R4: core pop, then ready with nothing waiting
    core_pop();
    chk("R4 R cleared", core_ctrl, 32'h6000_0000);
    core_pop();
    chk("R4 idle ready no effect", core_ctrl, 32'h6000_0000);

    // R6: core push
    chk("R6 ready when empty", {31'd0, core_tx_ready}, 32'd1);
    core_push(32'hB1B1_0001);
    chk("R6 W set", core_ctrl, 32'h6000_0002);
    chk("R6 ready low when full", {31'd0, core_tx_ready}, 32'd0);

    // R7: push while full is dropped
    core_push(32'hB2B2_0002);
    chk("R7 c2h overrun pulse", {31'd0, c2h_overrun}, 32'd1);
    chk("R7 W stays", {31'd0, core_ctrl[1]}, 32'd1);
    @(negedge clk);
    chk("R7 pulse one cycle", {31'd0, c2h_overrun}, 32'd0);

    // R9: control read is side-effect free, writes ignored
    dbg_write(5'd5, 32'hC1C1_0001);
    dbg_read(5'd4, rd);
    chk("R9 ctrl read value", rd, 32'h6000_0003);
    chk("R9 flags unchanged", core_ctrl, 32'h6000_0003);
    dbg_write(5'd4, 32'h0000_0000);
    chk("R9 ctrl write ignored", core_ctrl, 32'h6000_0003);
    dbg_write(5'd9, 32'hDEAD_BEEF);
    chk("R9 unused write ignored", core_rx_data, 32'hC1C1_0001);
    dbg_read(5'd7, rd);
    chk("R9 unused read zero", rd, 32'd0);

    // R8: host read consumes; second read is stale
    dbg_read(5'd5, rd);
    chk("R7 R8 read returns kept word", rd, 32'hB1B1_0001);
    chk("R8 W cleared", {31'd0, core_ctrl[1]}, 32'd0);
    dbg_read(5'd5, rd);
    chk("R8 second read same word", rd, 32'hB1B1_0001);
    chk("R8 W still clear", {31'd0, core_ctrl[1]}, 32'd0);

    // R10: host write meets core pop (R holds C1)
    @(negedge clk);
    dbg_addr = 5'd5; dbg_wr = 1'b1; dbg_wdata = 32'hC2C2_0002;
    core_rx_ready = 1'b1;
    @(posedge clk); #1;
    core_q.push_back(32'hC2C2_0002);  // monitor already took C1 at this edge
    @(negedge clk); dbg_wr = 1'b0; core_rx_ready = 1'b0; dbg_addr = '0;
    chk("R10 R stays after collide", {31'd0, core_ctrl[0]}, 32'd1);
    chk("R10 new word held", core_rx_data, 32'hC2C2_0002);
    chk("R10 no h2c overrun", {31'd0, h2c_overrun}, 32'd0);
    core_pop();

    // R10: core push meets host read while W set
    core_push(32'hB3B3_0003);
    @(negedge clk);
    dbg_addr = 5'd5; dbg_rd = 1'b1; core_tx_valid = 1'b1; core_tx_data = 32'hB4B4_0004;
    #1;
    chk("R10 ready during consume", {31'd0, core_tx_ready}, 32'd1);
    chk("R10 read returns old word", dbg_rdata, 32'hB3B3_0003);
    @(negedge clk); dbg_rd = 1'b0; core_tx_valid = 1'b0; dbg_addr = '0;
    chk("R10 W stays", {31'd0, core_ctrl[1]}, 32'd1);
    chk("R10 no c2h overrun", {31'd0, c2h_overrun}, 32'd0);
    dbg_read(5'd5, rd);
    chk("R10 new core word", rd, 32'hB4B4_0004);
    chk("R3 R4 queue drained", core_q.size(), 32'd0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule